// File: doc/BRIEF.md
# T1 Transmit Timing-Master Clock Generator

This block produces the transmit backplane bit clock and the frame pulse for a single T1 link when the link is the timing master. A 1.544 Mb/s bit-rate enable, `bitEn`, comes from the surrounding clock domain. Each enable cycle moves the block one bit through a 193-position frame. The frame is one framing bit followed by 24 channels of 8 bits each. For every bit that is to be clocked, the block emits a clock pulse one system cycle wide. On the framing position it emits a frame pulse of the same width.

The block runs in one of two modes. In full mode every bit of the frame is clocked. In fractional mode the clock pulses only on the bits of the selected channels, so the clock has gaps. No dedicated bit selects fractional mode. The block enters it when any per-channel gap setting or any per-channel 56K setting is non-zero and the per-channel control enable is set. If such settings are present while the control enable is clear, the block reports a configuration error and keeps clocking in full mode.

When the link is a timing slave, the block drops its output enables so that the clock and frame pins can be driven from outside. It keeps its own outputs low, and it holds its frame position on the framing bit until master operation resumes.

Top module: `t1_txclk_master`

## Requirements
- R1: With `masterSel`=1, `clkOe` and `fsOe` are 1. With `masterSel`=0, both are 0, `txClkOut` and `txFsOut` stay 0, and the frame position returns to the framing bit. The first enabled bit after master operation resumes is therefore the framing bit.
- R2: After reset, the first `bitEn` is the framing bit. Each later `bitEn` advances one position through the order: framing bit, then channel 0 bits 0..7, then channel 1, and so on up to channel 23 bit 7, then the framing bit again. The frame has 193 positions.
- R3: In full mode, `txClkOut` pulses once for every `bitEn`, on all 193 positions.
- R4: `txFsOut` is a pulse one cycle wide for the framing position only, in both modes.
- R5: Fractional mode (`fracMode`=1) holds exactly when `chanGap` or `ch56k` has any bit set and `ctrlEn`=1. In fractional mode the framing position produces no clock pulse.
- R6: In fractional mode, channel c with `chanGap[c]`=1 produces no clock pulses on any of its 8 bits. Channel 0 is the first channel after the framing bit.
- R7: In fractional mode, channel c with `ch56k[c]`=1 and `chanGap[c]`=0 is clocked on bits 0..6 only. Bit 7, its last, is not clocked.
- R8: `cfgErr`=1 exactly when `chanGap` or `ch56k` has any bit set while `ctrlEn`=0. The block then stays in full mode (`fracMode`=0) and clocks every bit.
- R9: A clock or frame pulse appears in the system cycle directly after the cycle in which `bitEn` was 1, and never without a `bitEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle strobe per T1 bit period |
| masterSel | input | 1 | 1 = timing master, 0 = timing slave |
| ctrlEn | input | 1 | Per-channel control enable |
| chanGap | input | 24 | Per-channel gap; bit c = 1 removes channel c |
| ch56k | input | 24 | Per-channel 56K; bit c = 1 drops bit 7 of channel c |
| txClkOut | output | 1 | Gated transmit bit clock pulse |
| txFsOut | output | 1 | Frame pulse on the framing position |
| clkOe | output | 1 | Output enable for the clock pin |
| fsOe | output | 1 | Output enable for the frame pin |
| fracMode | output | 1 | Fractional mode is active |
| cfgErr | output | 1 | Gap or 56K settings present without control enable |

## Verification
The bench walks every position of whole frames against a position model. An off-by-one counter would show up as a slipped frame pulse or a 192- or 194-bit frame. A design that clocks the framing bit in fractional mode would produce one extra pulse per frame. One that drops the wrong bit in 56K channels would gap bit 0 instead of bit 7. The bench sets gap bits with the control enable clear, so a decoder that ignores the enable would wrongly enter fractional mode. It also switches to slave in mid-frame and back. A design that does not rewind its position would then restart somewhere inside a channel rather than on the framing bit.

// File: rtl/t1_txclk_pkg.sv
package t1_txclk_pkg;
  // Position strobes passed from the frame sequencer to the gating datapath.
  typedef struct packed {
    logic adv;       // bit strobe accepted while master
    logic frameBit;  // current position is the framing bit
    logic lastBit;   // current position is the last bit of a channel
  } posStrobe_t;
endpackage

// File: rtl/t1_txclk_mode.sv
module t1_txclk_mode #(
  parameter int CHANNELS = 24
) (
  input  logic                ctrlEn,
  input  logic [CHANNELS-1:0] chanGap,
  input  logic [CHANNELS-1:0] ch56k,
  output logic                fracMode,
  output logic                cfgErr
);
  logic anySet;
  always_comb begin
    anySet   = |(chanGap | ch56k);
    fracMode = anySet & ctrlEn;
    cfgErr   = anySet & ~ctrlEn;
  end
endmodule

// File: rtl/t1_txclk_ctrl.sv
module t1_txclk_ctrl
  import t1_txclk_pkg::*;
#(
  parameter int CHANNELS = 24,
  parameter int CH_BITS  = 8,
  localparam int CW = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int BW = (CH_BITS > 1) ? $clog2(CH_BITS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitEn,
  input  logic          masterSel,
  output posStrobe_t    stb,
  output logic [CW-1:0] chanIdx
);
  localparam logic [CW-1:0] LAST_CH  = CW'(CHANNELS - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(CH_BITS - 1);

  logic          inFrame;
  logic [BW-1:0] bitIdx;

  always_ff @(posedge clk) begin
    if (!rstN || !masterSel) begin
      inFrame <= 1'b1;
      chanIdx <= '0;
      bitIdx  <= '0;
    end else if (bitEn) begin
      if (inFrame) begin
        inFrame <= 1'b0;
        chanIdx <= '0;
        bitIdx  <= '0;
      end else if (bitIdx == LAST_BIT) begin
        bitIdx <= '0;
        if (chanIdx == LAST_CH) inFrame <= 1'b1;
        else                    chanIdx <= chanIdx + 1'b1;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  always_comb begin
    stb.adv      = bitEn & masterSel;
    stb.frameBit = inFrame;
    stb.lastBit  = ~inFrame & (bitIdx == LAST_BIT);
  end
endmodule

// File: rtl/t1_txclk_dpath.sv
module t1_txclk_dpath
  import t1_txclk_pkg::*;
#(
  parameter int CHANNELS = 24,
  localparam int CW = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  posStrobe_t          stb,
  input  logic [CW-1:0]       chanIdx,
  input  logic                fracMode,
  input  logic [CHANNELS-1:0] chanGap,
  input  logic [CHANNELS-1:0] ch56k,
  output logic                txClkOut,
  output logic                txFsOut
);
  logic gateOn;
  logic chGapped;
  logic chDrop;

  always_comb begin
    chGapped = chanGap[chanIdx];
    chDrop   = ch56k[chanIdx] & stb.lastBit;
    if (!fracMode)         gateOn = 1'b1;
    else if (stb.frameBit) gateOn = 1'b0;
    else                   gateOn = ~(chGapped | chDrop);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txClkOut <= 1'b0;
      txFsOut  <= 1'b0;
    end else begin
      txClkOut <= stb.adv & gateOn;
      txFsOut  <= stb.adv & stb.frameBit;
    end
  end
endmodule

// File: rtl/t1_txclk_master.sv
module t1_txclk_master
  import t1_txclk_pkg::*;
#(
  parameter int CHANNELS = 24,
  parameter int CH_BITS  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitEn,
  input  logic                masterSel,
  input  logic                ctrlEn,
  input  logic [CHANNELS-1:0] chanGap,
  input  logic [CHANNELS-1:0] ch56k,
  output logic                txClkOut,
  output logic                txFsOut,
  output logic                clkOe,
  output logic                fsOe,
  output logic                fracMode,
  output logic                cfgErr
);
  localparam int CW = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;

  posStrobe_t    stb;
  logic [CW-1:0] chanIdx;

  assign clkOe = masterSel;
  assign fsOe  = masterSel;

  t1_txclk_mode #(.CHANNELS(CHANNELS)) u_mode (
    .ctrlEn(ctrlEn), .chanGap(chanGap), .ch56k(ch56k),
    .fracMode(fracMode), .cfgErr(cfgErr)
  );

  t1_txclk_ctrl #(.CHANNELS(CHANNELS), .CH_BITS(CH_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .masterSel(masterSel),
    .stb(stb), .chanIdx(chanIdx)
  );

  t1_txclk_dpath #(.CHANNELS(CHANNELS)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .chanIdx(chanIdx),
    .fracMode(fracMode), .chanGap(chanGap), .ch56k(ch56k),
    .txClkOut(txClkOut), .txFsOut(txFsOut)
  );
endmodule

// File: rtl/t1_txclk_checker.sv
module t1_txclk_checker (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic masterSel,
  input logic txClkOut,
  input logic txFsOut,
  input logic fracMode,
  input logic cfgErr
);
  // R9
  clk_needs_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    txClkOut |-> $past(bitEn));
  // R1
  fs_needs_master_chk: assert property (@(posedge clk) disable iff (!rstN)
    txFsOut |-> $past(bitEn && masterSel));
  // R4
  fs_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    txFsOut |=> !txFsOut);
  // R8
  err_excl_frac_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgErr && fracMode));
  // R5
  frame_gapped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txFsOut && $past(fracMode)) |-> !txClkOut);
  // R3
  frame_clocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txFsOut && !$past(fracMode)) |-> txClkOut);
endmodule

bind t1_txclk_master t1_txclk_checker u_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .masterSel(masterSel),
  .txClkOut(txClkOut), .txFsOut(txFsOut), .fracMode(fracMode), .cfgErr(cfgErr)
);

// File: tb/t1_txclk_master_bench.sv
`timescale 1ns/1ps
module t1_txclk_master_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitEn = 1'b0;
  logic        masterSel = 1'b1;
  logic        ctrlEn = 1'b0;
  logic [23:0] chanGap = '0;
  logic [23:0] ch56k = '0;
  logic txClkOut, txFsOut, clkOe, fsOe, fracMode, cfgErr;

  int vecCnt = 0;
  int errCnt = 0;

  always #2 clk = ~clk;

  t1_txclk_master u_t1_txclk_master (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .masterSel(masterSel),
    .ctrlEn(ctrlEn), .chanGap(chanGap), .ch56k(ch56k),
    .txClkOut(txClkOut), .txFsOut(txFsOut), .clkOe(clkOe), .fsOe(fsOe),
    .fracMode(fracMode), .cfgErr(cfgErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic expClk(input int pos, input logic frac);
    int c, b;
    if (!frac) return 1'b1;
    if (pos == 0) return 1'b0;
    c = (pos - 1) / 8;
    b = (pos - 1) % 8;
    if (chanGap[c]) return 1'b0;
    if (ch56k[c] && b == 7) return 1'b0;
    return 1'b1;
  endfunction

  // One bit strobe; outputs sampled at the negedge after the accepting edge.
  task automatic oneBit(input int pos, input logic frac, input string req);
    @(negedge clk) bitEn = 1'b1;
    @(negedge clk) bitEn = 1'b0;
    check(req, {31'd0, txClkOut}, {31'd0, expClk(pos, frac)});
    check("R4", {31'd0, txFsOut}, {31'd0, pos == 0});
    @(negedge clk);
    check("R9", {30'd0, txClkOut, txFsOut}, 32'd0);
  endtask

  task automatic runFrame(input logic frac, input string req);
    int pulses = 0;
    for (int p = 0; p < 193; p++) begin
      oneBit(p, frac, req);
    end
  endtask

  task automatic testReset;
    @(negedge clk);
    check("R1", {30'd0, clkOe, fsOe}, 32'd3);
    check("R9", {30'd0, txClkOut, txFsOut}, 32'd0);
    check("R5", {31'd0, fracMode}, 32'd0);
    check("R8", {31'd0, cfgErr}, 32'd0);
  endtask

  task automatic testFull;
    runFrame(1'b0, "R3");
    runFrame(1'b0, "R2");
  endtask

  task automatic testGap;
    ctrlEn = 1'b1;
    chanGap = 24'h80_0A05;
    @(negedge clk);
    check("R5", {31'd0, fracMode}, 32'd1);
    runFrame(1'b1, "R6");
  endtask

  task automatic test56k;
    chanGap = 24'h00_0001;
    ch56k = 24'hC0_0183;
    @(negedge clk);
    runFrame(1'b1, "R7");
  endtask

  task automatic testCfgErr;
    ctrlEn = 1'b0;
    @(negedge clk);
    check("R8", {30'd0, cfgErr, fracMode}, 32'd2);
    runFrame(1'b0, "R8");
    chanGap = '0; ch56k = '0;
    @(negedge clk);
    check("R8", {31'd0, cfgErr}, 32'd0);
  endtask

  task automatic testSlave;
    for (int p = 0; p < 30; p++) oneBit(p, 1'b0, "R2");
    @(negedge clk) masterSel = 1'b0;
    @(negedge clk);
    check("R1", {30'd0, clkOe, fsOe}, 32'd0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk) bitEn = 1'b1;
      @(negedge clk) bitEn = 1'b0;
      check("R1", {30'd0, txClkOut, txFsOut}, 32'd0);
    end
    masterSel = 1'b1;
    @(negedge clk);
    check("R1", {30'd0, clkOe, fsOe}, 32'd3);
    runFrame(1'b0, "R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFull();
    testGap();
    test56k();
    testCfgErr();
    testSlave();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    #1000000;
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule